// File: doc/BRIEF.md
# Activity Watchdog with Latched Fault and Reset Pulse

This block supervises a single logic line, typically a processor heartbeat or clock divided down to a slow rate, and raises an alarm when that line stops moving. Each change of level, upward or downward, counts as a sign of life and restarts a timeout. If no change arrives before the programmed timeout elapses, the block raises two outputs at once. One is a sticky fault level that stays up until the fault-report logic issues a clear strobe. The other is a one-shot reset pulse with its own programmable width. Each output has its own polarity control, so either can be used active-high or active-low.

Time is counted with two tick enables supplied by the chip: a millisecond tick for the timeout and a 10 µs tick for the pulse width. The timeout code selects `(code+1) × STEP_MS` milliseconds, which spans 200 ms to 12.8 s with the default step. The width code selects `2^code × 10 µs`, clamped at 10 ms. If the line stays idle after an expiry, the timer starts over and fires again one period later.

The design has four pieces. An input stage holds the line in a two-flop synchronizer and flags any level change. An expiry timer counts idle milliseconds. A two-state latch machine has the states HOLD_OFF and HOLD_ON. A two-state pulse machine has the states PULSE_REST and PULSE_DRIVE. The latch goes from HOLD_OFF to HOLD_ON on expiry, and from HOLD_ON to HOLD_OFF on a clear strobe when no expiry arrives in the same cycle. The pulse machine goes from PULSE_REST to PULSE_DRIVE on expiry. It stays in PULSE_DRIVE and reloads its width when another expiry arrives. It returns to PULSE_REST when the width count runs out.

Top module: `activity_watchdog`

## Requirements
- R1: A rising or a falling level change on `wd_pin`, seen through a two-flop synchronizer, restarts the idle count, and no expiry occurs in the clock after such a change is detected.
- R2: With `wd_pin` held steady, an expiry occurs on the clock edge at which the `(timeout_code+1)×STEP_MS`-th `tick_ms` since the last restart is seen.
- R3: On the clock after an expiry, the latched fault state goes high and stays high until it is cleared.
- R4: On the clock after an expiry, the pulse state goes high and stays high until the programmed number of `tick_10us` ticks has been seen.
- R5: `fault_clear` high at a clock edge lowers the latched fault state, unless an expiry occurs at that same edge; in that case the fault state is set.
- R6: While `wd_pin` stays idle, the timer restarts after each expiry and fires again one full period later.
- R7: `fault_latched_o` equals the latched fault state XOR `inv_latched`, and `reset_pulse_o` equals the pulse state XOR `inv_pulse`.
- R8: The pulse width in `tick_10us` ticks is `2^width_exp`, clamped to `MAX_PULSE_TICKS` (default 1000, which is 10 ms).
- R9: An expiry that arrives while the pulse is high reloads the full width, so the pulse is stretched and not ended.
- R10: During and right after reset, both the latched fault state and the pulse state are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle enable once per millisecond |
| tick_10us | input | 1 | One-cycle enable once per 10 µs |
| wd_pin | input | 1 | Monitored activity line (asynchronous) |
| timeout_code | input | TO_W (6) | Timeout = (code+1)×STEP_MS ms |
| width_exp | input | PW_EXP_W (4) | Pulse width = 2^code ticks of 10 µs, clamped |
| inv_latched | input | 1 | Inverts the latched fault output |
| inv_pulse | input | 1 | Inverts the reset pulse output |
| fault_clear | input | 1 | Strobe that clears the latched fault |
| fault_latched_o | output | 1 | Latched fault level after polarity |
| reset_pulse_o | output | 1 | Reset pulse after polarity |

## Verification
Two collisions matter here. A clear strobe can fall in the same cycle as an expiry. The bench provokes this by holding `fault_clear` high through a period of inactivity, and it checks that the expiry wins at that edge and that the clear takes effect one edge later. An expiry can also land while the reset pulse is still running. Pairing the shortest timeout with a long width provokes this, and the pulse must stay high without a gap. Both cases are judged against a behavioural model that is compared with the outputs on every clock.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    typedef enum logic {
        HOLD_OFF = 1'b0,
        HOLD_ON  = 1'b1
    } hold_state_t;

    typedef enum logic {
        PULSE_REST  = 1'b0,
        PULSE_DRIVE = 1'b1
    } pulse_state_t;

endpackage

// File: rtl/wdg_edge_sense.sv
module wdg_edge_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic change_o
);
    logic meta_q;
    logic stable_q;
    logic prior_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= 1'b0;
            stable_q <= 1'b0;
            prior_q  <= 1'b0;
        end else begin
            meta_q   <= line_i;
            stable_q <= meta_q;
            prior_q  <= stable_q;
        end
    end

    // any level change between consecutive synchronized samples
    assign change_o = stable_q ^ prior_q;

endmodule

// File: rtl/wdg_expiry_timer.sv
module wdg_expiry_timer #(
    parameter int TO_W    = 6,
    parameter int STEP_MS = 200
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_ms,
    input  logic            restart_i,
    input  logic [TO_W-1:0] timeout_code,
    output logic            expire_o
);
    localparam int MAX_TICKS = STEP_MS * (2 ** TO_W);
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);

    logic [CNT_W-1:0] idle_cnt;
    logic [CNT_W-1:0] limit;

    always_comb begin
        limit = CNT_W'((32'(timeout_code) + 32'd1) * 32'(STEP_MS));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_cnt <= '0;
            expire_o <= 1'b0;
        end else if (restart_i) begin
            idle_cnt <= '0;
            expire_o <= 1'b0;
        end else if (tick_ms) begin
            if (idle_cnt == limit - CNT_W'(1)) begin
                idle_cnt <= '0;
                expire_o <= 1'b1;
            end else begin
                idle_cnt <= idle_cnt + CNT_W'(1);
                expire_o <= 1'b0;
            end
        end else begin
            expire_o <= 1'b0;
        end
    end

    // activity must suppress the very next expiry
    assert_restart_blocks_expiry_R1 : assert property (
        @(posedge clk) disable iff (!rst_n) restart_i |=> !expire_o);

    // an expiry is always triggered by a millisecond tick
    assert_expiry_on_tick_R2 : assert property (
        @(posedge clk) disable iff (!rst_n) expire_o |-> $past(tick_ms));

endmodule

// File: rtl/wdg_fault_latch.sv
module wdg_fault_latch
    import wdg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic expire_i,
    input  logic clear_i,
    output logic held_o
);
    hold_state_t state_q;
    hold_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HOLD_OFF: if (expire_i) state_d = HOLD_ON;
            HOLD_ON:  if (clear_i && !expire_i) state_d = HOLD_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HOLD_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        held_o = (state_q == HOLD_ON);
    end

    assert_latch_set_by_expiry_R3 : assert property (
        @(posedge clk) disable iff (!rst_n) $rose(held_o) |-> $past(expire_i));

    assert_latch_drop_by_clear_R5 : assert property (
        @(posedge clk) disable iff (!rst_n)
        $fell(held_o) |-> ($past(clear_i) && !$past(expire_i)));

endmodule

// File: rtl/wdg_pulse_shaper.sv
module wdg_pulse_shaper
    import wdg_pkg::*;
#(
    parameter int PW_EXP_W        = 4,
    parameter int MAX_PULSE_TICKS = 1000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_10us,
    input  logic                expire_i,
    input  logic [PW_EXP_W-1:0] width_exp,
    output logic                pulse_o
);
    localparam int PW_CNT_W = $clog2(MAX_PULSE_TICKS + 1);

    pulse_state_t        state_q;
    pulse_state_t        state_d;
    logic [PW_CNT_W-1:0] left_q;
    logic [PW_CNT_W-1:0] left_d;
    logic [PW_CNT_W-1:0] width_ticks;
    logic [31:0]         raw_width;

    always_comb begin
        raw_width = 32'd1 << width_exp;
        if (raw_width > 32'(MAX_PULSE_TICKS))
            width_ticks = PW_CNT_W'(MAX_PULSE_TICKS);
        else
            width_ticks = PW_CNT_W'(raw_width);
    end

    always_comb begin
        state_d = state_q;
        left_d  = left_q;
        unique case (state_q)
            PULSE_REST: begin
                if (expire_i) begin
                    state_d = PULSE_DRIVE;
                    left_d  = width_ticks;
                end
            end
            PULSE_DRIVE: begin
                if (expire_i) begin
                    left_d = width_ticks;
                end else if (tick_10us) begin
                    if (left_q == PW_CNT_W'(1)) begin
                        state_d = PULSE_REST;
                        left_d  = '0;
                    end else begin
                        left_d = left_q - PW_CNT_W'(1);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PULSE_REST;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
        end
    end

    always_comb begin
        pulse_o = (state_q == PULSE_DRIVE);
    end

    assert_pulse_starts_on_expiry_R4 : assert property (
        @(posedge clk) disable iff (!rst_n) $rose(pulse_o) |-> $past(expire_i));

    assert_pulse_count_nonzero_R8 : assert property (
        @(posedge clk) disable iff (!rst_n) pulse_o |-> (left_q != '0));

    assert_pulse_retrigger_R9 : assert property (
        @(posedge clk) disable iff (!rst_n) (pulse_o && expire_i) |=> pulse_o);

endmodule

// File: rtl/activity_watchdog.sv
module activity_watchdog #(
    parameter int TO_W            = 6,
    parameter int STEP_MS         = 200,
    parameter int PW_EXP_W        = 4,
    parameter int MAX_PULSE_TICKS = 1000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_ms,
    input  logic                tick_10us,
    input  logic                wd_pin,
    input  logic [TO_W-1:0]     timeout_code,
    input  logic [PW_EXP_W-1:0] width_exp,
    input  logic                inv_latched,
    input  logic                inv_pulse,
    input  logic                fault_clear,
    output logic                fault_latched_o,
    output logic                reset_pulse_o
);
    logic line_change;
    logic expire;
    logic held;
    logic pulse;

    wdg_edge_sense u_sense (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_i   (wd_pin),
        .change_o (line_change)
    );

    wdg_expiry_timer #(
        .TO_W    (TO_W),
        .STEP_MS (STEP_MS)
    ) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_ms      (tick_ms),
        .restart_i    (line_change),
        .timeout_code (timeout_code),
        .expire_o     (expire)
    );

    wdg_fault_latch u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .expire_i (expire),
        .clear_i  (fault_clear),
        .held_o   (held)
    );

    wdg_pulse_shaper #(
        .PW_EXP_W        (PW_EXP_W),
        .MAX_PULSE_TICKS (MAX_PULSE_TICKS)
    ) u_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_10us (tick_10us),
        .expire_i  (expire),
        .width_exp (width_exp),
        .pulse_o   (pulse)
    );

    assign fault_latched_o = held ^ inv_latched;
    assign reset_pulse_o   = pulse ^ inv_pulse;

    // both alarms must start together on one expiry
    assert_alarms_rise_together_R4 : assert property (
        @(posedge clk) disable iff (!rst_n)
        ($past(expire) && !$past(fault_clear)) |-> (held && pulse));

endmodule

// File: tb/test_activity_watchdog.sv
`timescale 1ns/1ps
module test_activity_watchdog;
    localparam int STEP = 3;
    localparam int MAXP = 1000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_ms = 1'b0;
    logic       tick_10us = 1'b0;
    logic       wd_pin = 1'b0;
    logic [5:0] timeout_code = 6'd1;
    logic [3:0] width_exp = 4'd2;
    logic       inv_latched = 1'b0;
    logic       inv_pulse = 1'b0;
    logic       fault_clear = 1'b0;
    logic       fault_latched_o;
    logic       reset_pulse_o;

    int checks = 0;
    int errors = 0;
    int cycle = 0;
    string phase = "R10";
    bit done = 0;

    // behavioural reference state
    int  pin_hist[$] = '{0, 0, 0};
    int  m_idle = 0;
    bit  m_exp = 0;
    bit  m_hold = 0;
    bit  m_pulse = 0;
    int  m_left = 0;

    always #2 clk = ~clk;

    activity_watchdog #(.STEP_MS(STEP), .MAX_PULSE_TICKS(MAXP)) i_activity_watchdog (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .tick_10us(tick_10us),
        .wd_pin(wd_pin), .timeout_code(timeout_code), .width_exp(width_exp),
        .inv_latched(inv_latched), .inv_pulse(inv_pulse), .fault_clear(fault_clear),
        .fault_latched_o(fault_latched_o), .reset_pulse_o(reset_pulse_o)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cycle);
        end
    endtask

    function automatic int width_of(int e);
        int w = 1 << e;
        return (w > MAXP) ? MAXP : w;
    endfunction

    // reference model, updated on each clock, compared shortly after
    always @(posedge clk) begin
        bit seen_change;
        bit fire;
        bit prev_exp;
        cycle++;
        if (!rst_n) begin
            pin_hist = '{0, 0, 0};
            m_idle = 0; m_exp = 0; m_hold = 0; m_pulse = 0; m_left = 0;
        end else begin
            seen_change = (pin_hist[1] != pin_hist[2]);
            pin_hist.push_front(int'(wd_pin));
            void'(pin_hist.pop_back());
            prev_exp = m_exp;
            fire = 0;
            if (seen_change) m_idle = 0;
            else if (tick_ms) begin
                if (m_idle + 1 == (int'(timeout_code) + 1) * STEP) begin
                    m_idle = 0; fire = 1;
                end else m_idle++;
            end
            if (prev_exp) m_hold = 1;
            else if (fault_clear) m_hold = 0;
            if (prev_exp) begin
                m_pulse = 1; m_left = width_of(int'(width_exp));
            end else if (m_pulse && tick_10us) begin
                if (m_left == 1) begin m_pulse = 0; m_left = 0; end
                else m_left--;
            end
            m_exp = fire;
        end
        #1;
        if (!done) begin
            check(phase, "fault_latched_o", int'(fault_latched_o), int'(m_hold ^ inv_latched));
            check(phase, "reset_pulse_o", int'(reset_pulse_o), int'(m_pulse ^ inv_pulse));
        end
    end

    // tick generators: ms tick every 2nd cycle, 10us tick every 3rd cycle
    initial begin
        int n = 0;
        forever begin
            @(negedge clk);
            n++;
            tick_ms   = (n % 2 == 0);
            tick_10us = (n % 3 == 0);
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic toggle_for(int n, int every);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i % every == 0) wd_pin = ~wd_pin;
        end
    endtask

    initial begin
        int hi_len;
        bit gap;
        idle(3);
        // R10: reset state
        check("R10", "fault at reset", int'(fault_latched_o), 0);
        check("R10", "pulse at reset", int'(reset_pulse_o), 0);
        rst_n = 1'b1;
        idle(2);
        check("R10", "fault after reset", int'(fault_latched_o), 0);

        // R1: both edge directions keep the timer from expiring
        phase = "R1";
        timeout_code = 6'd1;
        toggle_for(120, 5);
        check("R1", "no fault with activity", int'(fault_latched_o), 0);
        check("R1", "no pulse with activity", int'(reset_pulse_o), 0);

        // R2/R3/R4: stop activity, expect both alarms
        phase = "R3";
        idle(40);
        check("R3", "fault set after idle", int'(fault_latched_o), 1);

        // R6: further idling keeps firing
        phase = "R6";
        idle(60);
        check("R3", "fault still held", int'(fault_latched_o), 1);

        // R5: clear while active
        phase = "R5";
        toggle_for(10, 3);
        @(negedge clk); fault_clear = 1'b1;
        @(negedge clk); fault_clear = 1'b0; wd_pin = ~wd_pin;
        idle(1);
        check("R5", "fault cleared", int'(fault_latched_o), 0);

        // R5: clear held across an expiry (collision)
        fault_clear = 1'b1;
        idle(60);
        fault_clear = 1'b0;
        toggle_for(20, 3);

        // R7: inverted outputs
        phase = "R7";
        inv_latched = 1'b1; inv_pulse = 1'b1;
        idle(1);
        check("R7", "inverted fault idle", int'(fault_latched_o), int'(m_hold) ^ 1);
        idle(40);
        toggle_for(40, 3);
        inv_latched = 1'b0; inv_pulse = 1'b0;
        @(negedge clk); fault_clear = 1'b1;
        @(negedge clk); fault_clear = 1'b0;

        // R8: clamped width, activity resumes after the pulse starts
        phase = "R8";
        width_exp = 4'd12;
        timeout_code = 6'd2;
        idle(40);
        while (reset_pulse_o == 1'b0) @(negedge clk);
        hi_len = 0;
        while (reset_pulse_o == 1'b1 && hi_len < 5000) begin
            @(negedge clk);
            if (hi_len % 7 == 0) wd_pin = ~wd_pin;
            hi_len++;
        end
        check("R8", "clamped width near 3000 cycles",
              int'(hi_len >= 2990 && hi_len <= 3003), 1);

        // R9: expiry during pulse stretches it
        phase = "R9";
        width_exp = 4'd5;
        timeout_code = 6'd0;
        idle(30);
        gap = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (reset_pulse_o == 1'b0) gap = 1;
        end
        check("R9", "pulse never drops while retriggered", int'(gap), 0);
        toggle_for(150, 3);
        check("R9", "pulse ends once activity returns", int'(reset_pulse_o), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog %s: actual hung expected finished", phase);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule